// File: doc/BRIEF.md
# Two-Wire Bus Master Receiver with Event Status Codes

This block is the read-side engine of a two-wire serial bus master. It generates START, repeated START and STOP conditions on open-drain clock and data lines. It sends a 7-bit target address with the read bit set and then clocks in data bytes. After each byte it either acknowledges or declines, as the controlling logic asks. SCL timing comes from a fixed divider. Each bit is split into four equal quarter-periods of `DIV` clocks.

The sequencer halts after every bus event. At that point it raises an event flag and publishes one fixed 8-bit status code that names the event. While the flag is up, SCL is held low and nothing moves on the bus. The controller picks the next action by pulsing `cmd_go` together with three command bits: start, stop and acknowledge-enable. It can also load the data register beforehand. If another master wins the bus, the block lets go of both lines at once and reports the loss. In state 0x10, a loaded address with a write bit hands the held bus to a separate transmitter.

Top module: `twi_rx_master`

## Requirements
- R1: After reset the status is 0xF8, the flag, `stop_busy` and `xmit_grant` are low, and neither line is driven.
- R2: A START requested from idle (`cmd_go` with `cmd_sta`=1) is issued only once SCL and SDA have both stayed high for at least one bit period (4·DIV clocks). The bus counts as free straight out of reset. On completion the status is 0x08 and the flag is set.
- R3: While the flag is set after any event other than arbitration loss, SCL is held low. The flag and status stay unchanged until `cmd_go` is pulsed.
- R4: In status 0x08 or 0x10, `cmd_go` sends the data register MSB first when its bit 0 is 1 (read). It then samples the ninth bit: low gives status 0x40 and high gives 0x48.
- R5: In status 0x40 or 0x50, `cmd_go` clocks in eight bits MSB first into `data_rd`. The master then drives the ninth bit low if `cmd_ack`=1 (status 0x50) or leaves it high if `cmd_ack`=0 (status 0x58). `data_rd` keeps the previous byte until the new byte is complete.
- R6: In status 0x48 or 0x58, `cmd_go` with start=1 and stop=0 issues a repeated START and ends with status 0x10 and the flag set.
- R7: In status 0x48 or 0x58, `cmd_go` with start=0 and stop=1 issues a STOP. `stop_busy` is high from the command until the STOP is complete. The block then returns to idle with status 0xF8, the flag low and both lines released.
- R8: In status 0x48 or 0x58, `cmd_go` with both start and stop set issues a STOP, waits for a free bus, then issues a START, ending with status 0x08.
- R9: In status 0x48 or 0x58, `cmd_go` with both start and stop clear is ignored. The flag stays set and the status stays unchanged.
- R10: If the master leaves SDA high but samples it low during an address bit, or during its own NOT ACK bit, the status becomes 0x38. The flag is set and both lines are released from the next clock on.
- R11: In status 0x38, `cmd_go` with start=0 gives status 0xF8 with the flag low. With start=1 the flag drops, the status stays 0x38, and a START is issued once the bus is free, ending with status 0x08.
- R12: In status 0x08 or 0x10, `cmd_go` with data register bit 0 = 0 sends nothing. It raises `xmit_grant`, clears the flag and keeps SCL held low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_go | input | 1 | Flag-clear strobe that launches the next action |
| cmd_sta | input | 1 | Start request, sampled with `cmd_go` |
| cmd_sto | input | 1 | Stop request, sampled with `cmd_go` |
| cmd_ack | input | 1 | Acknowledge-enable, sampled with `cmd_go` |
| data_we | input | 1 | Load strobe for the data register |
| data_wr | input | 8 | Value loaded into the data register (address + R/W bit) |
| data_rd | output | 8 | Data register: loaded address or last received byte |
| status | output | 8 | Event status code |
| irq | output | 1 | Event flag |
| stop_busy | output | 1 | Stop request pending; clears when STOP is sent |
| xmit_grant | output | 1 | Bus handed to the transmitter path |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench puts a behavioural target and a rival master on a wired-AND bus. It walks a read transaction that mixes ACK and NOT ACK replies, a repeated START and a STOP. Arbitration is stolen in two places: during the first address bit and during the master's NOT ACK bit. A design that checks for arbitration on every released bit would report a loss on ordinary data bits. A design that keeps driving after a loss would leave SCL low on a contested bus. A START is requested while the rival still holds SDA, so a sequencer that ignores the bus-free window would issue START on a busy bus. The bench also covers four other faults: a command with neither start nor stop that wrongly releases the bus, a STOP+START chain that stops after the STOP, a data register that changes mid-byte, and a write address at 0x10 that is clocked out instead of handed off.

// File: rtl/twi_rx_pkg.sv
package twi_rx_pkg;

    localparam logic [7:0] ST_START  = 8'h08;
    localparam logic [7:0] ST_RSTART = 8'h10;
    localparam logic [7:0] ST_ARB    = 8'h38;
    localparam logic [7:0] ST_AACK   = 8'h40;
    localparam logic [7:0] ST_ANACK  = 8'h48;
    localparam logic [7:0] ST_DACK   = 8'h50;
    localparam logic [7:0] ST_DNACK  = 8'h58;
    localparam logic [7:0] ST_IDLE   = 8'hF8;

    typedef enum logic [2:0] {
        S_IDLE, S_WAITFREE, S_START, S_RSTART, S_BIT, S_HOLD, S_STOP, S_HANDOFF
    } seq_t;

    typedef struct packed {
        logic sta;
        logic sto;
        logic ack;
    } cmd_t;

    function automatic logic status_ok(input logic [7:0] s);
        return s inside {ST_START, ST_RSTART, ST_ARB, ST_AACK,
                         ST_ANACK, ST_DACK, ST_DNACK, ST_IDLE};
    endfunction

endpackage

// File: rtl/twi_rx_tick.sv
module twi_rx_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // quarter-bit ticks never come back to back (bit timing behind R2)
    p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/twi_rx_busfree.sv
module twi_rx_busfree #(
    parameter int BIT_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic scl,
    input  logic sda,
    output logic free
);
    localparam int FW = $clog2(BIT_CYC + 1);

    logic [FW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            hi_cnt <= FW'(BIT_CYC);           // idle bus at reset counts as free
        else if (!(scl && sda))
            hi_cnt <= '0;
        else if (hi_cnt != FW'(BIT_CYC))
            hi_cnt <= hi_cnt + 1'b1;
    end

    assign free = (hi_cnt == FW'(BIT_CYC)) && scl && sda;

    // any low level on the bus withdraws the free indication (R2)
    p_busy_clears_free_r2: assert property (@(posedge clk) disable iff (rst)
        !(scl && sda) |=> !free);

endmodule

// File: rtl/twi_rx_seq.sv
module twi_rx_seq
    import twi_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       bus_free,
    input  logic       sda_in,
    input  logic       cmd_go,
    input  cmd_t       cmd,
    input  logic       data_we,
    input  logic [7:0] data_wr,
    output logic [7:0] data_rd,
    output logic [7:0] status,
    output logic       irq,
    output logic       stop_busy,
    output logic       xmit_grant,
    output logic       scl_low,
    output logic       sda_low
);
    seq_t       st;
    logic [1:0] ph;
    logic [3:0] bcnt;
    logic       addr_mode, ack_en_q, chain_sta, ack_seen;
    logic [7:0] dreg, rx_sh, stat;
    logic       flag, stop_q, grant_q, scl_q, sda_q;
    logic       out_bit, arb_bit;

    // level the master leaves on SDA for the current bit (1 = released)
    always_comb begin
        if (addr_mode) out_bit = (bcnt < 4'd8) ? dreg[3'd7 - bcnt[2:0]] : 1'b1;
        else           out_bit = (bcnt < 4'd8) ? 1'b1 : ~ack_en_q;
        arb_bit = addr_mode ? (bcnt < 4'd8) : (bcnt == 4'd8);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE; ph <= '0; bcnt <= '0;
            addr_mode <= 1'b0; ack_en_q <= 1'b0; chain_sta <= 1'b0; ack_seen <= 1'b0;
            dreg <= '0; rx_sh <= '0; stat <= ST_IDLE;
            flag <= 1'b0; stop_q <= 1'b0; grant_q <= 1'b0; scl_q <= 1'b0; sda_q <= 1'b0;
        end else begin
            if (data_we && st != S_BIT) dreg <= data_wr;

            if (cmd_go && flag) begin
                case (stat)
                    ST_START, ST_RSTART: begin
                        flag <= 1'b0;
                        if (dreg[0]) begin
                            st <= S_BIT; addr_mode <= 1'b1; bcnt <= '0; ph <= '0;
                        end else begin
                            st <= S_HANDOFF; grant_q <= 1'b1;
                        end
                    end
                    ST_AACK, ST_DACK: begin
                        flag <= 1'b0; st <= S_BIT; addr_mode <= 1'b0;
                        ack_en_q <= cmd.ack; bcnt <= '0; ph <= '0;
                    end
                    ST_ANACK, ST_DNACK: begin
                        if (cmd.sto) begin
                            flag <= 1'b0; st <= S_STOP; stop_q <= 1'b1;
                            chain_sta <= cmd.sta; ph <= '0;
                        end else if (cmd.sta) begin
                            flag <= 1'b0; st <= S_RSTART; ph <= '0;
                        end
                    end
                    ST_ARB: begin
                        flag <= 1'b0;
                        if (cmd.sta) begin st <= S_WAITFREE; ph <= '0; end
                        else stat <= ST_IDLE;
                    end
                    default: ;
                endcase
            end else if (cmd_go && !flag && st == S_IDLE && cmd.sta) begin
                st <= S_WAITFREE; ph <= '0;
            end else if (tick) begin
                ph <= ph + 2'd1;
                case (st)
                    S_WAITFREE: if (bus_free) begin st <= S_START; ph <= '0; end
                    S_START: case (ph)
                        2'd0: sda_q <= 1'b1;
                        2'd2: scl_q <= 1'b1;
                        2'd3: begin stat <= ST_START; flag <= 1'b1; st <= S_HOLD; end
                        default: ;
                    endcase
                    S_RSTART: case (ph)
                        2'd0: sda_q <= 1'b0;
                        2'd1: scl_q <= 1'b0;
                        2'd2: sda_q <= 1'b1;
                        default: begin
                            scl_q <= 1'b1; stat <= ST_RSTART; flag <= 1'b1; st <= S_HOLD;
                        end
                    endcase
                    S_STOP: case (ph)
                        2'd0: sda_q <= 1'b1;
                        2'd1: scl_q <= 1'b0;
                        2'd2: sda_q <= 1'b0;
                        default: begin
                            stop_q <= 1'b0;
                            if (chain_sta) st <= S_WAITFREE;
                            else begin st <= S_IDLE; stat <= ST_IDLE; end
                        end
                    endcase
                    S_BIT: case (ph)
                        2'd0: sda_q <= ~out_bit;
                        2'd1: scl_q <= 1'b0;
                        2'd2: begin
                            if (out_bit && !sda_in && arb_bit) begin
                                scl_q <= 1'b0; sda_q <= 1'b0;
                                stat <= ST_ARB; flag <= 1'b1; st <= S_IDLE;
                            end else if (addr_mode) begin
                                if (bcnt == 4'd8) ack_seen <= !sda_in;
                            end else if (bcnt < 4'd8) begin
                                rx_sh <= {rx_sh[6:0], sda_in};
                                if (bcnt == 4'd7) dreg <= {rx_sh[6:0], sda_in};
                            end
                        end
                        default: begin
                            scl_q <= 1'b1;
                            if (bcnt == 4'd8) begin
                                flag <= 1'b1; st <= S_HOLD;
                                if (addr_mode) stat <= ack_seen ? ST_AACK : ST_ANACK;
                                else           stat <= ack_en_q ? ST_DACK : ST_DNACK;
                            end else begin
                                bcnt <= bcnt + 4'd1;
                            end
                        end
                    endcase
                    default: ;
                endcase
            end
        end
    end

    assign data_rd    = dreg;
    assign status     = stat;
    assign irq        = flag;
    assign stop_busy  = stop_q;
    assign xmit_grant = grant_q;
    assign scl_low    = scl_q;
    assign sda_low    = sda_q;

    p_status_legal_r1: assert property (@(posedge clk) disable iff (rst)
        status_ok(stat));
    p_hold_scl_r3: assert property (@(posedge clk) disable iff (rst)
        (flag && stat != ST_ARB) |-> scl_q);
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (flag && !cmd_go) |=> flag);
    p_stop_self_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(stop_q) |-> (st == S_IDLE || st == S_WAITFREE));
    p_arb_release_r10: assert property (@(posedge clk) disable iff (rst)
        (flag && stat == ST_ARB) |-> (!scl_q && !sda_q));
    p_handoff_scl_r12: assert property (@(posedge clk) disable iff (rst)
        grant_q |-> scl_q);

endmodule

// File: rtl/twi_rx_master.sv
module twi_rx_master
    import twi_rx_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_go,
    input  logic       cmd_sta,
    input  logic       cmd_sto,
    input  logic       cmd_ack,
    input  logic       data_we,
    input  logic [7:0] data_wr,
    output logic [7:0] data_rd,
    output logic [7:0] status,
    output logic       irq,
    output logic       stop_busy,
    output logic       xmit_grant,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam int BIT_CYC = 4 * DIV;

    logic tick, bus_free;
    cmd_t cmd;

    assign cmd = '{sta: cmd_sta, sto: cmd_sto, ack: cmd_ack};

    twi_rx_tick #(.DIV(DIV)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    twi_rx_busfree #(.BIT_CYC(BIT_CYC)) u_free (
        .clk(clk), .rst(rst), .scl(scl_in), .sda(sda_in), .free(bus_free)
    );

    twi_rx_seq u_seq (
        .clk(clk), .rst(rst), .tick(tick), .bus_free(bus_free), .sda_in(sda_in),
        .cmd_go(cmd_go), .cmd(cmd), .data_we(data_we), .data_wr(data_wr),
        .data_rd(data_rd), .status(status), .irq(irq), .stop_busy(stop_busy),
        .xmit_grant(xmit_grant), .scl_low(scl_oe), .sda_low(sda_oe)
    );

endmodule

// File: tb/twi_rx_master_test.sv
module twi_rx_master_test;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic       ld;
        logic [7:0] byt;
        logic       sta, sto, ack;
        logic [7:0] st;
        logic       cd;
        logic [7:0] dat;
    } vec_t;

    function automatic logic [7:0] sbyte(input int i);
        return 8'h96 + 8'(i * 8'h2B);
    endfunction

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h08, 1'b0, 8'h00},
        '{1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 8'h40, 1'b0, 8'h00},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h50, 1'b1, 8'h96},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h58, 1'b1, 8'hC1},
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h10, 1'b0, 8'h00},
        '{1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 8'h40, 1'b0, 8'h00},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h50, 1'b1, 8'h96},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h50, 1'b1, 8'hC1},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h58, 1'b1, 8'hEC},
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'hF8, 1'b0, 8'h00}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_go = 1'b0, cmd_sta = 1'b0, cmd_sto = 1'b0, cmd_ack = 1'b0;
    logic data_we = 1'b0;
    logic [7:0] data_wr = '0;
    logic [7:0] data_rd, status;
    logic irq, stop_busy, xmit_grant, scl_oe, sda_oe;
    wire  scl, sda;

    int checks = 0, fails = 0;

    // bus agents
    logic rival_hold = 1'b0, rival_nack = 1'b0, slv_kill = 1'b0, slv_ack_addr = 1'b1;
    logic slv_act = 1'b0, slv_addr_ph = 1'b0, slv_drv = 1'b0, slv_mnack = 1'b0;
    logic p_scl = 1'b1, p_sda = 1'b1;
    logic [7:0] slv_acap = '0;
    int slv_bit = 0, slv_byte = 0;
    wire rival = rival_hold | (rival_nack & slv_act & !slv_addr_ph & (slv_bit == 8));

    assign scl = !scl_oe;
    assign sda = !(sda_oe | slv_drv | rival);

    always #(CLK_P / 2) clk = ~clk;

    twi_rx_master uut (
        .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_sta(cmd_sta), .cmd_sto(cmd_sto),
        .cmd_ack(cmd_ack), .data_we(data_we), .data_wr(data_wr), .data_rd(data_rd),
        .status(status), .irq(irq), .stop_busy(stop_busy), .xmit_grant(xmit_grant),
        .scl_in(scl), .sda_in(sda), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // behavioural read target
    always @(posedge clk) begin
        int nb;
        logic aph, keep;
        int bidx;
        logic [7:0] b;
        p_scl <= scl;
        p_sda <= sda;
        if (rst || slv_kill) begin
            slv_act <= 1'b0; slv_drv <= 1'b0;
        end else if (p_scl && scl && p_sda && !sda) begin
            slv_act <= 1'b1; slv_addr_ph <= 1'b1; slv_bit <= -1; slv_byte <= 0;
            slv_drv <= 1'b0; slv_acap <= '0;
        end else if (p_scl && scl && !p_sda && sda) begin
            slv_act <= 1'b0; slv_drv <= 1'b0;
        end else if (slv_act && !p_scl && scl) begin
            if (slv_addr_ph && slv_bit < 8) slv_acap <= {slv_acap[6:0], sda};
            if (!slv_addr_ph && slv_bit == 8) slv_mnack <= sda;
        end else if (slv_act && p_scl && !scl) begin
            nb = slv_bit + 1; aph = slv_addr_ph; keep = 1'b1; bidx = slv_byte;
            if (nb == 9) begin
                nb = 0;
                if (aph) begin aph = 1'b0; keep = slv_ack_addr; end
                else begin bidx = slv_byte + 1; keep = !slv_mnack; end
            end
            b = sbyte(bidx);
            slv_bit <= nb; slv_addr_ph <= aph; slv_byte <= bidx; slv_act <= keep;
            if (!keep)    slv_drv <= 1'b0;
            else if (aph) slv_drv <= (nb == 8) && slv_ack_addr;
            else          slv_drv <= (nb < 8) && !b[3'(7 - nb)];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] b);
        @(negedge clk); data_we = 1'b1; data_wr = b;
        @(negedge clk); data_we = 1'b0;
    endtask

    task automatic go(input logic s, input logic p, input logic a);
        @(negedge clk); cmd_sta = s; cmd_sto = p; cmd_ack = a; cmd_go = 1'b1;
        @(negedge clk); cmd_go = 1'b0; cmd_sta = 1'b0; cmd_sto = 1'b0; cmd_ack = 1'b0;
    endtask

    task automatic wait_done(input logic [7:0] exp);
        for (int i = 0; i < 3000; i++) begin
            if (irq || (exp == 8'hF8 && status == 8'hF8 && !stop_busy)) break;
            @(negedge clk);
        end
    endtask

    task automatic step(input string tag, input logic s, input logic p,
                        input logic a, input logic [7:0] exp);
        go(s, p, a);
        wait_done(exp);
        chk(tag, {24'd0, status}, {24'd0, exp});
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] held, addr;
        held = '0; addr = '0;
        do_reset;
        // R1 reset state
        chk("R1 status", {24'd0, status}, 32'hF8);
        chk("R1 flag/busy/grant", {29'd0, irq, stop_busy, xmit_grant}, 32'd0);
        chk("R1 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);

        // table walk: R2 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].ld) begin load(VECS[i].byt); held = VECS[i].byt; addr = VECS[i].byt; end
            go(VECS[i].sta, VECS[i].sto, VECS[i].ack);
            if (VECS[i].cd) begin
                repeat (20) @(negedge clk);
                chk($sformatf("R5 hold before byte end step %0d", i), {24'd0, data_rd}, {24'd0, held});
            end
            wait_done(VECS[i].st);
            chk($sformatf("R2/R4/R5/R6/R7 status step %0d", i), {24'd0, status}, {24'd0, VECS[i].st});
            if (VECS[i].cd) begin
                chk($sformatf("R5 data step %0d", i), {24'd0, data_rd}, {24'd0, VECS[i].dat});
                held = VECS[i].dat;
            end
            if (VECS[i].st == 8'h40)
                chk($sformatf("R4 address MSB first step %0d", i), {24'd0, slv_acap}, {24'd0, addr});
            if (VECS[i].st == 8'h50) begin
                // R3 held with SCL low, no progress
                repeat (100) @(negedge clk);
                chk("R3 scl held low", {31'd0, scl_oe}, 32'd1);
                chk("R3 flag/status frozen", {23'd0, irq, status}, {23'd1, 8'h50});
            end
        end
        chk("R7 lines released after stop", {30'd0, scl_oe, sda_oe}, 32'd0);

        // R9 neither bit in 0x58, then R7 stop_busy
        step("R2 start", 1'b1, 1'b0, 1'b0, 8'h08);
        load(8'hA1);
        step("R4 addr ack", 1'b0, 1'b0, 1'b0, 8'h40);
        step("R5 nack byte", 1'b0, 1'b0, 1'b0, 8'h58);
        go(1'b0, 1'b0, 1'b0);
        repeat (80) @(negedge clk);
        chk("R9 command ignored", {23'd0, irq, status}, {23'd1, 8'h58});
        chk("R9 scl still held", {31'd0, scl_oe}, 32'd1);
        go(1'b0, 1'b1, 1'b0);
        chk("R7 stop_busy set", {31'd0, stop_busy}, 32'd1);
        wait_done(8'hF8);
        chk("R7 idle after stop", {22'd0, irq, stop_busy, status}, {24'd0, 8'hF8});

        // R8 address NACK then STOP+START
        slv_ack_addr = 1'b0;
        step("R2 start", 1'b1, 1'b0, 1'b0, 8'h08);
        load(8'hA1);
        step("R4 addr nack", 1'b0, 1'b0, 1'b0, 8'h48);
        slv_ack_addr = 1'b1;
        step("R8 stop then start", 1'b1, 1'b1, 1'b0, 8'h08);
        chk("R8 stop_busy cleared", {31'd0, stop_busy}, 32'd0);

        // R12 write address at 0x10 hands off
        load(8'hA1);
        step("R4 addr ack", 1'b0, 1'b0, 1'b0, 8'h40);
        step("R5 nack byte", 1'b0, 1'b0, 1'b0, 8'h58);
        step("R6 repeated start", 1'b1, 1'b0, 1'b0, 8'h10);
        load(8'hA0);
        go(1'b0, 1'b0, 1'b0);
        repeat (100) @(negedge clk);
        chk("R12 grant raised, flag low", {30'd0, xmit_grant, irq}, 32'h2);
        chk("R12 scl held, no address bits", {30'd0, scl_oe, sda}, 32'h2);
        chk("R12 target saw no address", {24'd0, slv_acap}, 32'd0);
        do_reset;
        chk("R1 reset clears grant", {23'd0, xmit_grant, status}, {24'd0, 8'hF8});

        // R10 loss in address bit, R11 release
        step("R2 start", 1'b1, 1'b0, 1'b0, 8'h08);
        rival_hold = 1'b1;
        load(8'hA1);
        step("R10 loss in address", 1'b0, 1'b0, 1'b0, 8'h38);
        chk("R10 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);
        go(1'b0, 1'b0, 1'b0);
        chk("R11 release to idle", {23'd0, irq, status}, {24'd0, 8'hF8});
        // R2 start waits while SDA held low
        go(1'b1, 1'b0, 1'b0);
        repeat (200) @(negedge clk);
        chk("R2 no start on busy bus", {23'd0, irq, status}, {24'd0, 8'hF8});
        rival_hold = 1'b0;
        wait_done(8'h08);
        chk("R2 start after bus frees", {23'd0, irq, status}, {23'd1, 8'h08});
        // R11 queued start after loss
        rival_hold = 1'b1;
        load(8'hA1);
        step("R10 loss in address", 1'b0, 1'b0, 1'b0, 8'h38);
        go(1'b1, 1'b0, 1'b0);
        repeat (100) @(negedge clk);
        chk("R11 start queued", {23'd0, irq, status}, {24'd0, 8'h38});
        rival_hold = 1'b0;
        wait_done(8'h08);
        chk("R11 queued start issued", {23'd0, irq, status}, {23'd1, 8'h08});

        // R10 loss during NOT ACK bit
        load(8'hA1);
        step("R4 addr ack", 1'b0, 1'b0, 1'b0, 8'h40);
        rival_nack = 1'b1;
        step("R10 loss in nack bit", 1'b0, 1'b0, 1'b0, 8'h38);
        chk("R10 lines released at nack", {30'd0, scl_oe, sda_oe}, 32'd0);
        @(negedge clk); slv_kill = 1'b1; rival_nack = 1'b0;
        @(negedge clk); slv_kill = 1'b0;
        go(1'b0, 1'b0, 1'b0);
        chk("R11 idle after nack loss", {23'd0, irq, status}, {24'd0, 8'hF8});

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule